// File: doc/BRIEF.md
# Gated System-Management Interrupt Request Combiner

This block merges three system-management interrupt request sources (hardware, software and external) into one active-low interrupt line for the processor. A one-cycle pulse on any source is caught in a sticky pending bit for that source. The bit stays set until its own clear strobe arrives. A gate bit decides whether the pending state reaches the line. Software sets and clears the gate through two strobes.

The line is low only while the gate is 1 and at least one pending bit is set. If software closes the gate, the line goes high while the requests stay pending. When the gate opens again, any request still pending pulls the line low once more. A set and a clear of the gate in the same cycle leave the gate at 0. A separate pending flag reports whether any source is pending, whatever the gate holds. Both outputs come from registers, so they never glitch, and each one responds at the first clock edge after its cause.

Top module: `smi_gate`

## Requirements
- R1: While reset is held and after it is released, the gate is 0, all pending bits are 0, `smiN` is 1 and `anyPending` is 0.
- R2: A 1 on `reqPulse[i]` in one cycle sets pending bit i at that edge. Bit 0 is hardware, bit 1 is software and bit 2 is external. The bit stays set with no further pulses until `srcClr[i]` clears it, and `anyPending` is 1 from that edge onward.
- R3: When the gate is 1 and at least one pending bit is set after an edge, `smiN` is 0 from that same edge.
- R4: A `gateClr` pulse makes `smiN` 1 at the next edge, even when requests remain pending.
- R5: A `gateSet` pulse without `gateClr` makes `smiN` 0 at the next edge when any request is pending after that edge, including requests that were latched while the gate was closed.
- R6: When `gateSet` and `gateClr` are both 1 in the same cycle, the gate becomes 0 and `smiN` is 1 after that edge.
- R7: `srcClr[i]` clears only pending bit i. Once every pending bit is clear, `anyPending` is 0 and `smiN` is 1 after that edge.
- R8: When `reqPulse[i]` and `srcClr[i]` are both 1 in the same cycle, pending bit i is set after the edge.
- R9: `anyPending` is the OR of the pending bits whatever the gate value, and `smiN` is never 0 while `anyPending` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqPulse | input | 3 | One-cycle request pulses: bit 0 hardware, bit 1 software, bit 2 external |
| srcClr | input | 3 | Per-source pending clear strobes, same bit order as `reqPulse` |
| gateSet | input | 1 | Strobe that sets the gate bit |
| gateClr | input | 1 | Strobe that clears the gate bit (wins over `gateSet`) |
| smiN | output | 1 | Registered active-low interrupt line |
| anyPending | output | 1 | Registered OR of all pending bits |

## Verification
Two pairs of functions can land in the same cycle. The first is a gate set with a gate clear. The second is a source request with that source's clear. The bench covers both by sweeping all 256 combinations of the eight input bits, in two orders and from different prior states. After each edge it compares both outputs with a bench model built from the priority rules. Each mismatch is blamed on the rule that the cycle exercised, R6 for a simultaneous gate set and clear and R8 for a request meeting its own clear.

// File: rtl/smi_gate_pkg.sv
package smi_gate_pkg;
  localparam int SRC_N = 3;

  typedef enum int unsigned {
    SRC_HW  = 0,
    SRC_SW  = 1,
    SRC_EXT = 2
  } srcIdx_e;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic             gateOn;   // gate value after this edge
    logic [SRC_N-1:0] setMask;  // pending bits to set
    logic [SRC_N-1:0] clrMask;  // pending bits to clear
  } ctrlStrobe_t;
endpackage

// File: rtl/smi_gate_ctrl.sv
module smi_gate_ctrl
  import smi_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] reqPulse,
  input  logic [SRC_N-1:0] srcClr,
  input  logic             gateSet,
  input  logic             gateClr,
  output ctrlStrobe_t      strobe
);
  logic gateQ;
  logic gateNext;

  // Clear dominates a simultaneous set
  always_comb begin
    gateNext = gateQ;
    if (gateClr)      gateNext = 1'b0;
    else if (gateSet) gateNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gateQ <= 1'b0;
    else        gateQ <= gateNext;
  end

  assign strobe.gateOn = gateNext;

  // Per-source arbitration: a fresh request beats its own clear
  for (genvar i = 0; i < SRC_N; i++) begin : gSrc
    assign strobe.setMask[i] = reqPulse[i];
    assign strobe.clrMask[i] = srcClr[i] & ~reqPulse[i];
  end
endmodule

// File: rtl/smi_gate_dp.sv
module smi_gate_dp
  import smi_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ctrlStrobe_t strobe,
  output logic        smiN,
  output logic        anyPending
);
  logic [SRC_N-1:0] pendQ;
  logic [SRC_N-1:0] pendNext;
  logic             smiNQ;
  logic             anyQ;

  for (genvar i = 0; i < SRC_N; i++) begin : gPend
    assign pendNext[i] = (pendQ[i] & ~strobe.clrMask[i]) | strobe.setMask[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendQ <= '0;
      smiNQ <= 1'b1;
      anyQ  <= 1'b0;
    end else begin
      pendQ <= pendNext;
      smiNQ <= ~(strobe.gateOn & (|pendNext));
      anyQ  <= |pendNext;
    end
  end

  assign smiN       = smiNQ;
  assign anyPending = anyQ;
endmodule

// File: rtl/smi_gate.sv
module smi_gate
  import smi_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] reqPulse,
  input  logic [SRC_N-1:0] srcClr,
  input  logic             gateSet,
  input  logic             gateClr,
  output logic             smiN,
  output logic             anyPending
);
  ctrlStrobe_t strobe;

  smi_gate_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .reqPulse(reqPulse), .srcClr(srcClr),
    .gateSet(gateSet), .gateClr(gateClr), .strobe(strobe)
  );

  smi_gate_dp uDp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .smiN(smiN), .anyPending(anyPending)
  );
endmodule

// File: rtl/smi_gate_chk.sv
module smi_gate_chk
  import smi_gate_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_N-1:0] reqPulse,
  input logic [SRC_N-1:0] srcClr,
  input logic             gateSet,
  input logic             gateClr,
  input logic             smiN,
  input logic             anyPending
);
  // R4, R6: any gate clear leaves the line high after the edge
  a_r4_clr_negates: assert property (@(posedge clk) disable iff (!rst_n)
    gateClr |=> smiN);

  // R2, R8: a request always shows as pending after the edge
  a_r2_req_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|reqPulse) |=> anyPending);

  // R5: opening the gate together with a request drives the line low
  a_r5_gate_open_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    (gateSet && !gateClr && (|reqPulse)) |=> !smiN);

  // R9: the line is never low without a pending request
  a_r9_low_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !smiN |-> anyPending);

  // R7: pending state is sticky until some source clear arrives
  a_r7_sticky_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (anyPending && !(|srcClr)) |=> anyPending);
endmodule

bind smi_gate smi_gate_chk uChk (
  .clk(clk), .rst_n(rst_n), .reqPulse(reqPulse), .srcClr(srcClr),
  .gateSet(gateSet), .gateClr(gateClr), .smiN(smiN), .anyPending(anyPending)
);

// File: tb/smi_gate_test.sv
module smi_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reqPulse = '0;
  logic [2:0] srcClr = '0;
  logic       gateSet = 1'b0;
  logic       gateClr = 1'b0;
  logic       smiN;
  logic       anyPending;

  int nChecks = 0;
  int nFails  = 0;

  // bench model state, derived from the requirements
  logic       mGate = 1'b0;
  logic [2:0] mPend = '0;

  always #10 clk = ~clk;  // 50 MHz

  smi_gate uut (
    .clk(clk), .rst_n(rst_n), .reqPulse(reqPulse), .srcClr(srcClr),
    .gateSet(gateSet), .gateClr(gateClr), .smiN(smiN), .anyPending(anyPending)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tagFor(input logic [7:0] v);
    if (v[3] && v[4])                 return "R6";
    if (v[4])                         return "R4";
    if ((v[2:0] & v[7:5]) != 3'b000)  return "R8";
    if (v[7:5] != 3'b000)             return "R7";
    if (v[3])                         return "R5";
    if (v[2:0] != 3'b000)             return "R2";
    return "R9";
  endfunction

  // v: [2:0] request, [3] gate set, [4] gate clear, [7:5] source clear
  task automatic step(input logic [7:0] v, input string tag);
    reqPulse = v[2:0];
    gateSet  = v[3];
    gateClr  = v[4];
    srcClr   = v[7:5];
    @(posedge clk);
    if (v[4])      mGate = 1'b0;
    else if (v[3]) mGate = 1'b1;
    mPend = (mPend & ~(v[7:5] & ~v[2:0])) | v[2:0];
    @(negedge clk);
    reqPulse = '0; gateSet = 1'b0; gateClr = 1'b0; srcClr = '0;
    check(tag, smiN, ~(mGate & (|mPend)), "smiN");
    check(tag, anyPending, |mPend, "anyPending");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", smiN, 1'b1, "smiN in reset");
    check("R1", anyPending, 1'b0, "anyPending in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", smiN, 1'b1, "smiN after reset");
    check("R1", anyPending, 1'b0, "anyPending after reset");

    // latched while gate closed, then gate opens
    step(8'b000_0_0_001, "R2");
    step(8'b000_0_0_000, "R2");
    step(8'b000_0_1_000, "R5");
    step(8'b000_0_0_100, "R3");
    step(8'b000_1_0_000, "R4");
    step(8'b000_0_0_000, "R4");
    step(8'b000_0_1_000, "R5");
    step(8'b000_1_1_000, "R6");
    step(8'b000_0_1_000, "R5");
    step(8'b100_0_0_000, "R7");
    step(8'b001_0_0_000, "R7");
    step(8'b010_0_0_010, "R8");
    step(8'b010_0_0_000, "R7");
    step(8'b000_0_0_001, "R3");

    // near-exhaustive sweep over every input combination, two orders
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 256; i++) begin
        logic [7:0] v;
        v = (pass == 0) ? 8'(i) : 8'((i * 167 + 91) % 256);
        step(v, tagFor(v));
        step(8'(((i * 29) % 8) | ((i % 3 == 0) ? 8'h08 : 8'h00)), "R9");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule